// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block sits behind the comparators of an ARINC 429 line receiver and turns the tri-level return-to-zero bit stream into 32-bit words. It sees the line as two level flags, one for each polarity. When neither flag is set the line is NULL, and when both are set the line state is illegal. All timing is measured in ticks of a 1 MHz timing reference, which arrives as a one-cycle enable on the system clock. A rate input picks the high-speed or low-speed set of tolerance windows for the width of each pulse, the minimum NULL between bits, and the NULL length that marks a word boundary.

The receiver measures each pulse and each NULL. It keeps a bit count and an error flag for the word being built. When the line has stayed NULL for four bit times, the word is closed. A word is accepted only if the word had exactly 32 well-formed bits and nothing broke the rules. An accepted word comes out with a one-cycle valid strobe. A second mode input decides whether the last bit is passed through as data, or is replaced by a parity-error flag computed as odd parity over all 32 received bits.

Top module: `arx_word_rx`

## Requirements
- R1: While reset is held and after its release, `word_vld` is 0, `word_out` is all zeros and `par_err` is 0, until the first word is accepted.
- R2: With `rate_lo`=0, pulses of 4 to 6 ticks are valid bits. A pulse with `lvl_one` set is a 1 and a pulse with `lvl_zero` set is a 0. The first bit received lands in `word_out[0]` and the 32nd bit lands in `word_out[31]`.
- R3: With `rate_lo`=1, pulses of 34 to 42 ticks are valid bits, and the high-speed window no longer applies.
- R4: If any pulse of a word lies outside the window for the selected rate (for example 3 or 7 ticks at high speed, or 43 ticks at low speed), the whole word is rejected.
- R5: A NULL of at least 40 ticks (high speed) or 280 ticks (low speed) closes the current word. A NULL that is one tick shorter does not close it. This holds even when the boundary tick falls in the same cycle as the start of the next pulse.
- R6: A word closed with 31 or 33 bits is rejected.
- R7: A word is rejected in any of these cases: a NULL between two of its bits is shorter than 4 ticks (high speed) or 24 ticks (low speed); a pulse has both flags set; or a pulse follows the opposite pulse with no NULL between them.
- R8: With `par_mode`=1, `word_out[31]` and `par_err` are 1 exactly when the 32 received bits hold an even number of ones, and `word_out[30:0]` carries the first 31 bits. With `par_mode`=0, all 32 bits pass through and `par_err` is 0.
- R9: Each accepted word raises `word_vld` for exactly one cycle. A rejected word raises no strobe and leaves `word_out` unchanged.
- R10: Bits received after reset, before the first word boundary has been seen, never form an accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1us | input | 1 | One-cycle enable at 1 MHz, the timing reference |
| rate_lo | input | 1 | 1 selects the low-speed windows, 0 the high-speed windows |
| par_mode | input | 1 | 1 replaces bit 32 with the parity-error flag |
| lvl_one | input | 1 | Line is in the ONE state (asynchronous) |
| lvl_zero | input | 1 | Line is in the ZERO state (asynchronous) |
| word_out | output | 32 | Last accepted word, with bit 1 in position 0 |
| word_vld | output | 1 | One-cycle strobe for an accepted word |
| par_err | output | 1 | Parity-error flag of the last accepted word |

## Verification
Two things can happen in the same cycle. The word-closing tick of a NULL can be counted on the very edge where the synchronized line leaves NULL for the next word's first pulse. In that cycle the framer must close and clear one word while the meter starts timing the next pulse. The bench provokes this by separating two words with a NULL of exactly the boundary length, sent at both phases of the tick relative to the system clock, so that one phase puts the boundary tick on the transition edge. It expects two strobes, with the second word intact. A NULL one tick shorter must merge the two words, so that no strobe appears.

// File: rtl/arx_pkg.sv
// Shared types for the ARINC 429 word receiver.
// The line state is coded as {zero_flag, one_flag}, so the synchronized
// comparator flags map onto it directly.
package arx_pkg;

    typedef enum logic [1:0] {
        LN_NULL = 2'b00,
        LN_ONE  = 2'b01,
        LN_ZERO = 2'b10,
        LN_BAD  = 2'b11
    } line_e;

endpackage

// File: rtl/arx_line_sync.sv
// Synchronizes the two asynchronous comparator flags into the clock domain.
// Assumes the flags change slowly compared with clk (at least microseconds
// between changes), so a short skew between the two flags does not matter.
module arx_line_sync
    import arx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lvl_one,
    input  logic  lvl_zero,
    output line_e line_st
);

    logic [1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage: capture the raw flag pair
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= 2'b00;
                    else        stg[i] <= {lvl_zero, lvl_one};
                end
            end else begin : g_next
                // Later stages: pass the pair along
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= 2'b00;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign line_st = line_e'(stg[STAGES-1]);

endmodule

// File: rtl/arx_seg_meter.sv
// Measures how long the line stays in each state, in ticks of the timing
// reference. When the state changes, it reports the finished segment
// (its kind and its length). It raises gap once when a NULL reaches the
// word-boundary length. The tick seen on the edge where the state changes
// is counted toward the segment that is ending.
module arx_seg_meter
    import arx_pkg::*;
#(
    parameter int CW     = 9,
    parameter int HI_GAP = 40,
    parameter int LO_GAP = 280
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rate_lo,
    input  line_e         line_st,
    output logic          seg_end,
    output line_e         seg_kind,
    output logic [CW-1:0] seg_len,
    output logic          gap
);

    localparam logic [CW-1:0] CNT_SAT = '1;
    localparam logic [CW-1:0] HI_LIM  = CW'(HI_GAP - 1);
    localparam logic [CW-1:0] LO_LIM  = CW'(LO_GAP - 1);

    line_e         cur;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] gap_lim;

    // Count ticks, saturating; pick the boundary length for the rate
    always_comb begin
        cnt_inc = (tick && cnt != CNT_SAT) ? cnt + CW'(1) : cnt;
        gap_lim = rate_lo ? LO_LIM : HI_LIM;
    end

    // Track the current segment and report its end or a word boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= LN_NULL;
            cnt      <= '0;
            seg_end  <= 1'b0;
            seg_kind <= LN_NULL;
            seg_len  <= '0;
            gap      <= 1'b0;
        end else begin
            seg_end <= 1'b0;
            gap     <= tick && cur == LN_NULL && cnt == gap_lim;
            if (line_st != cur) begin
                seg_end  <= 1'b1;
                seg_kind <= cur;
                seg_len  <= cnt_inc;
                cur      <= line_st;
                cnt      <= '0;
            end else begin
                cnt <= cnt_inc;
            end
        end
    end

endmodule

// File: rtl/arx_framer.sv
// Builds a word from the measured segments. Each pulse is checked against
// the pulse-width window and each NULL against the minimum spacing. The
// framer shifts bits in with the first bit ending at position 0 and keeps
// a saturating bit count and a sticky error flag. At a word boundary it
// signals accept when the word was well formed and framing had been
// established, then clears its state for the next word.
module arx_framer
    import arx_pkg::*;
#(
    parameter int WORD_BITS   = 32,
    parameter int BW          = 6,
    parameter int CW          = 9,
    parameter int HI_PW_MIN   = 4,
    parameter int HI_PW_MAX   = 6,
    parameter int LO_PW_MIN   = 34,
    parameter int LO_PW_MAX   = 42,
    parameter int HI_NULL_MIN = 4,
    parameter int LO_NULL_MIN = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rate_lo,
    input  logic                 seg_end,
    input  line_e                seg_kind,
    input  logic [CW-1:0]        seg_len,
    input  logic                 gap,
    output logic                 accept,
    output logic [WORD_BITS-1:0] shreg,
    output logic [BW-1:0]        bcnt
);

    localparam logic [BW-1:0] BCNT_FULL = BW'(WORD_BITS);
    localparam logic [BW-1:0] BCNT_SAT  = BW'(WORD_BITS + 1);

    logic          armed;
    logic          err;
    logic          last_pulse;
    logic [CW-1:0] pw_min;
    logic [CW-1:0] pw_max;
    logic [CW-1:0] nl_min;
    logic          width_ok;

    // Select the windows for the rate and judge the finished segment
    always_comb begin
        pw_min   = rate_lo ? CW'(LO_PW_MIN)   : CW'(HI_PW_MIN);
        pw_max   = rate_lo ? CW'(LO_PW_MAX)   : CW'(HI_PW_MAX);
        nl_min   = rate_lo ? CW'(LO_NULL_MIN) : CW'(HI_NULL_MIN);
        width_ok = seg_len >= pw_min && seg_len <= pw_max;
        accept   = gap && armed && !err && bcnt == BCNT_FULL;
    end

    // Word assembly: the boundary clears, and a segment end updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            err        <= 1'b0;
            last_pulse <= 1'b0;
            bcnt       <= '0;
            shreg      <= '0;
        end else if (gap) begin
            armed      <= 1'b1;
            err        <= 1'b0;
            last_pulse <= 1'b0;
            bcnt       <= '0;
        end else if (seg_end) begin
            case (seg_kind)
                LN_ONE, LN_ZERO: begin
                    if (!width_ok || last_pulse) err <= 1'b1;
                    last_pulse <= 1'b1;
                    shreg      <= {seg_kind == LN_ONE, shreg[WORD_BITS-1:1]};
                    if (bcnt != BCNT_SAT) bcnt <= bcnt + BW'(1);
                end
                LN_NULL: begin
                    last_pulse <= 1'b0;
                    if (seg_len < nl_min) err <= 1'b1;
                end
                default: begin
                    last_pulse <= 1'b0;
                    err        <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/arx_word_fmt.sv
// Registers an accepted word for output. In parity mode the last bit is
// replaced by the parity-error flag (set when the ones count is even).
// The mode is sampled in the accept cycle; the output holds between words.
module arx_word_fmt #(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 par_mode,
    input  logic [WORD_BITS-1:0] word_in,
    output logic [WORD_BITS-1:0] word_out,
    output logic                 word_vld,
    output logic                 par_err
);

    logic odd_ones;

    // Odd-parity test over every received bit
    always_comb odd_ones = ^word_in;

    // Output register with the one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            word_vld <= 1'b0;
            par_err  <= 1'b0;
        end else begin
            word_vld <= accept;
            if (accept) begin
                word_out <= par_mode ? {~odd_ones, word_in[WORD_BITS-2:0]} : word_in;
                par_err  <= par_mode & ~odd_ones;
            end
        end
    end

endmodule

// File: rtl/arx_word_rx.sv
// ARINC 429 serial word receiver top: synchronizer, segment meter, framer
// and output formatter. Assumes tick_1us is a one-cycle pulse at 1 MHz and
// that rate_lo and par_mode stay stable while a word is being received.
module arx_word_rx
    import arx_pkg::*;
#(
    parameter int WORD_BITS   = 32,
    parameter int SYNC_STAGES = 2,
    parameter int HI_PW_MIN   = 4,
    parameter int HI_PW_MAX   = 6,
    parameter int LO_PW_MIN   = 34,
    parameter int LO_PW_MAX   = 42,
    parameter int HI_NULL_MIN = 4,
    parameter int LO_NULL_MIN = 24,
    parameter int HI_GAP      = 40,
    parameter int LO_GAP      = 280
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_1us,
    input  logic                 rate_lo,
    input  logic                 par_mode,
    input  logic                 lvl_one,
    input  logic                 lvl_zero,
    output logic [WORD_BITS-1:0] word_out,
    output logic                 word_vld,
    output logic                 par_err
);

    localparam int GAP_MAX = (LO_GAP > HI_GAP) ? LO_GAP : HI_GAP;
    localparam int LIM_MAX = (LO_PW_MAX > GAP_MAX) ? LO_PW_MAX : GAP_MAX;
    localparam int CW      = $clog2(LIM_MAX + 2);
    localparam int BW      = $clog2(WORD_BITS + 2);

    line_e                line_st;
    logic                 seg_end;
    line_e                seg_kind;
    logic [CW-1:0]        seg_len;
    logic                 meter_gap;
    logic                 accept;
    logic [WORD_BITS-1:0] frm_word;
    logic [BW-1:0]        frm_bcnt;

    arx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_one  (lvl_one),
        .lvl_zero (lvl_zero),
        .line_st  (line_st)
    );

    arx_seg_meter #(.CW(CW), .HI_GAP(HI_GAP), .LO_GAP(LO_GAP)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1us),
        .rate_lo  (rate_lo),
        .line_st  (line_st),
        .seg_end  (seg_end),
        .seg_kind (seg_kind),
        .seg_len  (seg_len),
        .gap      (meter_gap)
    );

    arx_framer #(
        .WORD_BITS   (WORD_BITS),
        .BW          (BW),
        .CW          (CW),
        .HI_PW_MIN   (HI_PW_MIN),
        .HI_PW_MAX   (HI_PW_MAX),
        .LO_PW_MIN   (LO_PW_MIN),
        .LO_PW_MAX   (LO_PW_MAX),
        .HI_NULL_MIN (HI_NULL_MIN),
        .LO_NULL_MIN (LO_NULL_MIN)
    ) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_lo  (rate_lo),
        .seg_end  (seg_end),
        .seg_kind (seg_kind),
        .seg_len  (seg_len),
        .gap      (meter_gap),
        .accept   (accept),
        .shreg    (frm_word),
        .bcnt     (frm_bcnt)
    );

    arx_word_fmt #(.WORD_BITS(WORD_BITS)) u_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .par_mode (par_mode),
        .word_in  (frm_word),
        .word_out (word_out),
        .word_vld (word_vld),
        .par_err  (par_err)
    );

endmodule

// File: rtl/arx_word_rx_chk.sv
// Property checker for the word receiver, attached by bind below.
// It watches the output strobe, the parity flag, and the boundary
// pulse and bit count that the meter and the framer hand to each other.
module arx_word_rx_chk #(
    parameter int WORD_BITS = 32,
    parameter int BW        = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 par_mode,
    input logic [WORD_BITS-1:0] word_out,
    input logic                 word_vld,
    input logic                 par_err,
    input logic                 gap,
    input logic [BW-1:0]        bcnt
);

    // R9: the strobe lasts a single cycle
    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    // R8: in parity mode the last bit carries the error flag
    a_r8_flag_in_bit32: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && $past(par_mode)) |-> (word_out[WORD_BITS-1] == par_err));

    // R8: in data mode no parity error is reported
    a_r8_no_flag_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !$past(par_mode)) |-> !par_err);

    // R5: a word only appears right after a boundary
    a_r5_strobe_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(gap));

    // R6: a boundary with the wrong bit count yields no word
    a_r6_count_gates_word: assert property (@(posedge clk) disable iff (!rst_n)
        (gap && bcnt != BW'(WORD_BITS)) |=> !word_vld);

endmodule

bind arx_word_rx arx_word_rx_chk #(.WORD_BITS(WORD_BITS), .BW(BW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_mode (par_mode),
    .word_out (word_out),
    .word_vld (word_vld),
    .par_err  (par_err),
    .gap      (meter_gap),
    .bcnt     (frm_bcnt)
);

// File: tb/tb_arx_word_rx.sv
`timescale 1ns/1ps
// Directed bench for the ARINC 429 word receiver: one task per scenario.
module tb_arx_word_rx;

    localparam int TP      = 2;      // clocks per tick
    localparam int HI_GAP  = 40;
    localparam int LO_GAP  = 280;
    localparam int WD_CYC  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1us;
    logic        rate_lo = 1'b0;
    logic        par_mode = 1'b0;
    logic        lvl_one = 1'b0;
    logic        lvl_zero = 1'b0;
    logic [31:0] word_out;
    logic        word_vld;
    logic        par_err;

    int          tdiv = 0;
    int          nvld = 0;
    int          ntests = 0;
    int          nfail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    // Tick generator: one clock in every TP
    always @(posedge clk) tdiv <= (tdiv == TP - 1) ? 0 : tdiv + 1;
    assign tick_1us = (tdiv == 0);

    arx_word_rx dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_1us (tick_1us),
        .rate_lo  (rate_lo),
        .par_mode (par_mode),
        .lvl_one  (lvl_one),
        .lvl_zero (lvl_zero),
        .word_out (word_out),
        .word_vld (word_vld),
        .par_err  (par_err)
    );

    // Strobe monitor, sampled away from the active edge
    always @(negedge clk) if (word_vld) nvld <= nvld + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hold(input logic one, input logic zero, input int n);
        lvl_one  = one;
        lvl_zero = zero;
        repeat (n * TP) @(negedge clk);
    endtask

    // mod: 0 none, 1 short null after bit idx, 2 both flags on bit idx,
    // 3 no null after bit idx
    task automatic send(input logic [63:0] bits, input int nb, input int pw, input int nw,
                        input int tail, input int mod, input int idx);
        for (int i = 0; i < nb; i++) begin
            if (mod == 2 && i == idx) hold(1'b1, 1'b1, pw);
            else                      hold(bits[i], ~bits[i], pw);
            if (i == nb - 1)               hold(1'b0, 1'b0, tail);
            else if (mod == 1 && i == idx) hold(1'b0, 1'b0, 3);
            else if (!(mod == 3 && i == idx)) hold(1'b0, 1'b0, nw);
        end
    endtask

    task automatic hi_word(input logic [63:0] bits, input int nb, input int pw);
        send(bits, nb, pw, 5, HI_GAP + 4, 0, 0);
    endtask

    task automatic expect_words(input int n0, input int n, input string req);
        check(nvld - n0 == n, req, 32'(nvld - n0), 32'(n));
    endtask

    task automatic t_reset;
        check(word_vld == 1'b0 && par_err == 1'b0, "R1 flags", {30'd0, word_vld, par_err}, 32'd0);
        check(word_out == 32'd0, "R1 word", word_out, 32'd0);
    endtask

    task automatic t_unarmed;
        int n0 = nvld;
        hi_word(64'h1234_5678, 32, 5);
        expect_words(n0, 0, "R10 word before first boundary");
        check(word_out == 32'd0, "R10 word_out untouched", word_out, 32'd0);
    endtask

    task automatic t_hi_data;
        logic [31:0] pats [3] = '{32'hA5C3_0F1E, 32'h0000_0001, 32'h8000_0000};
        for (int k = 0; k < 3; k++) begin
            int n0 = nvld;
            hi_word({32'd0, pats[k]}, 32, 5);
            expect_words(n0, 1, "R2 strobe count");
            check(word_out == pats[k], "R2 bit order", word_out, pats[k]);
            check(par_err == 1'b0, "R8 data mode flag", {31'd0, par_err}, 32'd0);
        end
    endtask

    task automatic t_hi_width;
        int n0;
        n0 = nvld; hi_word(64'h0F0F_3C3C, 32, 4);
        expect_words(n0, 1, "R2 width 4");
        check(word_out == 32'h0F0F_3C3C, "R2 width 4 word", word_out, 32'h0F0F_3C3C);
        n0 = nvld; hi_word(64'h1111_2222, 32, 6);
        expect_words(n0, 1, "R2 width 6");
        n0 = nvld; hi_word(64'hDEAD_BEEF, 32, 3);
        expect_words(n0, 0, "R4 width 3");
        n0 = nvld; hi_word(64'hDEAD_BEEF, 32, 7);
        expect_words(n0, 0, "R4 width 7");
        check(word_out == 32'h1111_2222, "R9 word held after reject", word_out, 32'h1111_2222);
    endtask

    task automatic t_lo;
        int n0;
        rate_lo = 1'b1;
        n0 = nvld; send(64'h6B2C_91E7, 32, 38, 40, LO_GAP + 4, 0, 0);
        expect_words(n0, 1, "R3 low rate");
        check(word_out == 32'h6B2C_91E7, "R3 low rate word", word_out, 32'h6B2C_91E7);
        n0 = nvld; send(64'h6B2C_91E7, 32, 43, 40, LO_GAP + 4, 0, 0);
        expect_words(n0, 0, "R4 low width 43");
        n0 = nvld; send(64'h6B2C_91E7, 32, 5, 40, LO_GAP + 4, 0, 0);
        expect_words(n0, 0, "R3 high width at low rate");
        rate_lo = 1'b0;
        hold(1'b0, 1'b0, LO_GAP);
    endtask

    task automatic t_count;
        int n0;
        n0 = nvld; hi_word(64'h7FFF_FFFF, 31, 5);
        expect_words(n0, 0, "R6 31 bits");
        n0 = nvld; hi_word(64'h1_2345_6789, 33, 5);
        expect_words(n0, 0, "R6 33 bits");
        n0 = nvld; hi_word(64'h2345_6789, 32, 5);
        expect_words(n0, 1, "R6 32 bits control");
    endtask

    task automatic t_shape;
        int n0;
        n0 = nvld; send(64'hA5C3_0F1E, 32, 5, 5, HI_GAP + 4, 1, 5);
        expect_words(n0, 0, "R7 short null");
        n0 = nvld; send(64'hA5C3_0F1E, 32, 5, 5, HI_GAP + 4, 2, 7);
        expect_words(n0, 0, "R7 both flags");
        n0 = nvld; send(64'hA5C3_0F1E, 32, 5, 5, HI_GAP + 4, 3, 0);
        expect_words(n0, 0, "R7 pulse without null");
        check(word_out == 32'h2345_6789, "R9 word held", word_out, 32'h2345_6789);
    endtask

    task automatic t_parity;
        logic [31:0] pats [4] = '{32'h0000_0007, 32'h8000_0003, 32'h0000_0003, 32'h8000_0001};
        par_mode = 1'b1;
        for (int k = 0; k < 4; k++) begin
            int n0 = nvld;
            logic odd = ^pats[k];
            logic [31:0] exp = {~odd, pats[k][30:0]};
            hi_word({32'd0, pats[k]}, 32, 5);
            expect_words(n0, 1, "R8 strobe");
            check(word_out == exp, "R8 word", word_out, exp);
            check(par_err == ~odd, "R8 flag", {31'd0, par_err}, {31'd0, ~odd});
        end
        par_mode = 1'b0;
    endtask

    task automatic t_boundary;
        for (int ph = 0; ph < TP; ph++) begin
            int n0;
            @(negedge clk);
            n0 = nvld;
            send(64'hCAFE_0001, 32, 5, 5, HI_GAP, 0, 0);
            hi_word(64'h0BAD_F00D, 32, 5);
            expect_words(n0, 2, "R5 exact boundary");
            check(word_out == 32'h0BAD_F00D, "R5 second word", word_out, 32'h0BAD_F00D);
            n0 = nvld;
            send(64'hCAFE_0002, 32, 5, 5, HI_GAP - 1, 0, 0);
            hi_word(64'h0BAD_F00E, 32, 5);
            expect_words(n0, 0, "R5 short boundary merges");
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_unarmed;
        t_hi_data;
        t_hi_width;
        t_lo;
        t_count;
        t_shape;
        t_parity;
        t_boundary;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            ntests++;
            nfail++;
            $display("FAIL watchdog act=%0d exp=%0d", WD_CYC, 0);
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

endmodule